// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block handles even parity on a PCI-style bus for a single agent. Each clock it folds the 32 address/data bits and the 4 command/byte-enable bits into one parity bit. When the agent is the one placing data on the bus, it drives that bit on the PAR pin one clock later, together with an output enable. It is the sourcing agent in three cases: as master during the address phase, as master on a write, and as target on a read.

When the agent is the one receiving data, the block records each completed data phase, meaning a clock in which IRDY# and TRDY# are both low. On the next clock it compares the PAR sampled from the bus with the parity it computed for that phase. A mismatch produces a one-clock status pulse. Outside Special Cycles, a mismatch also starts the PERR# sequence. PERR# is driven low for one clock, then driven high for a fixed number of clocks, and then released to tri-state. The surrounding bus interface supplies the role, direction and Special Cycle flags that describe each sampled clock.

Top module: `pci_parity_unit`

## Requirements
- R1: Whenever `par_oe_o` is high, `par_o` equals the XOR of the 32 `ad_i` bits and the 4 `cbe_n_i` bits sampled on the previous clock. The 37 bits formed by those 36 bits plus PAR therefore hold an even number of ones.
- R2: As master (`is_master_i`=1), a clock where `frame_n_i` is low after being high on the previous clock is an address phase. The next clock has `par_oe_o` high.
- R3: As master on a write (`is_write_i`=1), every clock with `irdy_n_i` low is followed by a clock with `par_oe_o` high.
- R4: As target on a read (`is_master_i`=0, `is_write_i`=0), every clock with `trdy_n_i` low is followed by a clock with `par_oe_o` high.
- R5: `par_oe_o` is low on a clock unless the previous clock met one of the conditions in R2, R3 or R4.
- R6: As receiver (master read or target write), take a clock k with `irdy_n_i` and `trdy_n_i` both low. If `par_i` on clock k+1 differs from the parity of clock k's data, then `perr_pulse_o` is high for one clock on clock k+2. On that same clock, `perr_n_o` is driven low with `perr_oe_o` high, provided `special_i` was low on clock k.
- R7: A clock where IRDY# and TRDY# are not both low is never checked, whatever `par_i` shows next.
- R8: A mismatch on a data phase flagged with `special_i`=1 still pulses `perr_pulse_o`, but does not drive PERR# low.
- R9: After each low clock, PERR# is driven high for `PERR_HOLD` clocks (default 2) before `perr_oe_o` falls, unless a new reportable error arrives in that time.
- R10: While `rst` is high and on the first clock after it, `par_oe_o`, `perr_oe_o` and `perr_pulse_o` are low and `perr_n_o` is high.
- R11: Reportable errors on consecutive clocks keep PERR# low on each of those clocks. The high period begins after the last of them.
- R12: While the agent is sourcing the data (master write or target read), completed data phases are not checked, and no pulse or PERR# results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ad_i | input | 32 | Address/data bus as sampled |
| cbe_n_i | input | 4 | Command/byte-enable bus as sampled (wire levels) |
| frame_n_i | input | 1 | FRAME# as sampled |
| irdy_n_i | input | 1 | IRDY# as sampled |
| trdy_n_i | input | 1 | TRDY# as sampled |
| par_i | input | 1 | PAR as sampled from the bus |
| is_master_i | input | 1 | 1 when this agent is the bus master, 0 when it is the target |
| is_write_i | input | 1 | 1 for a write transaction, 0 for a read |
| special_i | input | 1 | 1 while the current transaction is a Special Cycle |
| par_o | output | 1 | Generated parity for the previous clock |
| par_oe_o | output | 1 | Output enable for `par_o` |
| perr_n_o | output | 1 | PERR# drive level |
| perr_oe_o | output | 1 | Output enable for PERR# |
| perr_pulse_o | output | 1 | One-clock pulse for each detected data-phase mismatch |

## Verification
The assertions rely on two conditions. First, the role, direction and Special Cycle flags describe the same clock in which the bus strobes are sampled. Second, reset is held for at least two clocks, so that history looked up two clocks back never reaches into the time before reset. The bench holds reset for three clocks and sets all flags and strobes together in one drive step per clock. Because of this, even its random phase, which lets every flag and strobe change on each clock, stays within those conditions. PAR is mostly driven with the correct value for the previous clock's data and is deliberately flipped now and then. Directed sequences cover address phases, bursts in each role, errors during Special Cycles, errors on back-to-back clocks, and errors that arrive during the release window.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    localparam int AD_W_DEF   = 32;
    localparam int CBE_W_DEF  = 4;
    localparam int HOLD_DEF   = 2;
    localparam int LANE_BITS  = 8;

    // PERR# drive states: released, driven low, driven high before release
    typedef enum logic [1:0] {
        PERR_OFF  = 2'd0,
        PERR_LOW  = 2'd1,
        PERR_HIGH = 2'd2
    } perr_state_e;

    // Per-clock decode of the bus strobes for this agent
    typedef struct packed {
        logic addr;     // first clock of FRAME# low
        logic drive;    // this agent must drive PAR next clock
        logic xfer;     // completed data phase received by this agent
        logic special;  // phase belongs to a Special Cycle
    } phase_t;

    // True when this agent places the data on the bus
    function automatic logic sources_data(input logic master, input logic write);
        return master ? write : !write;
    endfunction

endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree
    import pci_par_pkg::*;
#(
    parameter int AD_W  = AD_W_DEF,
    parameter int CBE_W = CBE_W_DEF
) (
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    output logic             par
);
    localparam int LANES = (AD_W + LANE_BITS - 1) / LANE_BITS;

    logic [LANES-1:0] lane_par;

    // one XOR fold per byte lane, then a final fold with the command bits
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            localparam int LO = g * LANE_BITS;
            localparam int HI = (LO + LANE_BITS - 1 < AD_W) ? LO + LANE_BITS - 1 : AD_W - 1;
            assign lane_par[g] = ^ad[HI:LO];
        end
    endgenerate

    assign par = (^lane_par) ^ (^cbe);

endmodule

// File: rtl/pci_par_phase.sv
module pci_par_phase
    import pci_par_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_n,
    input  logic   irdy_n,
    input  logic   trdy_n,
    input  logic   is_master,
    input  logic   is_write,
    input  logic   special,
    output phase_t ph
);
    logic frame_q;
    logic src;
    logic own_strobe;

    always_ff @(posedge clk) begin
        if (rst) frame_q <= 1'b1;
        else     frame_q <= frame_n;
    end

    assign src        = sources_data(is_master, is_write);
    assign own_strobe = is_master ? !irdy_n : !trdy_n;

    always_comb begin
        ph.addr    = !frame_n && frame_q;
        ph.drive   = (is_master && ph.addr) || (src && own_strobe);
        ph.xfer    = !src && !irdy_n && !trdy_n;
        ph.special = special;
    end

    AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ph.addr |=> !ph.addr) else $error("address phase lasted two clocks"); // R2

endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen
    import pci_par_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph,
    input  logic   par_calc,
    output logic   par_o,
    output logic   par_oe_o
);
    // PAR trails the data it covers by exactly one clock
    always_ff @(posedge clk) begin
        if (rst) begin
            par_o    <= 1'b0;
            par_oe_o <= 1'b0;
        end else begin
            par_o    <= par_calc;
            par_oe_o <= ph.drive;
        end
    end

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
    import pci_par_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph,
    input  logic   par_calc,
    input  logic   par_i,
    output logic   err_pulse_o,
    output logic   err_report_o
);
    logic xfer_q;
    logic exp_q;
    logic spec_q;
    logic mismatch;

    // stage 1: remember the completed phase and its expected parity
    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q <= 1'b0;
            exp_q  <= 1'b0;
            spec_q <= 1'b0;
        end else begin
            xfer_q <= ph.xfer;
            exp_q  <= par_calc;
            spec_q <= ph.special;
        end
    end

    // stage 2: compare with PAR as it arrives one clock later
    assign mismatch     = xfer_q && (par_i != exp_q);
    assign err_report_o = mismatch && !spec_q;

    always_ff @(posedge clk) begin
        if (rst) err_pulse_o <= 1'b0;
        else     err_pulse_o <= mismatch;
    end

    AST_PULSE_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
        err_pulse_o |-> $past(xfer_q)) else $error("pulse without stored phase"); // R7

endmodule

// File: rtl/pci_perr_drv.sv
module pci_perr_drv
    import pci_par_pkg::*;
#(
    parameter int PERR_HOLD = HOLD_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic err_report,
    output logic perr_n_o,
    output logic perr_oe_o
);
    localparam int CW = (PERR_HOLD > 1) ? $clog2(PERR_HOLD) : 1;
    localparam logic [CW-1:0] HOLD_LAST = CW'(PERR_HOLD - 1);

    perr_state_e     state;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PERR_OFF;
            cnt   <= '0;
        end else if (err_report) begin
            state <= PERR_LOW;
            cnt   <= '0;
        end else begin
            unique case (state)
                PERR_LOW: begin
                    state <= PERR_HIGH;
                    cnt   <= HOLD_LAST;
                end
                PERR_HIGH: begin
                    if (cnt == '0) state <= PERR_OFF;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= PERR_OFF;
            endcase
        end
    end

    assign perr_oe_o = (state != PERR_OFF);
    assign perr_n_o  = (state != PERR_LOW);

    generate
        if (PERR_HOLD >= 2) begin : g_hold_chk
            AST_PERR_HIGH_BEFORE_FLOAT: assert property (@(posedge clk) disable iff (rst)
                $fell(perr_oe_o) |-> ($past(perr_n_o) && $past(perr_n_o, 2)))
                else $error("PERR# released without two high clocks"); // R9
        end
    endgenerate

    AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (perr_oe_o && !perr_n_o && !err_report) |=> (perr_oe_o && perr_n_o))
        else $error("PERR# low not followed by high drive"); // R9

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter int AD_W      = AD_W_DEF,
    parameter int CBE_W     = CBE_W_DEF,
    parameter int PERR_HOLD = HOLD_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_n_i,
    input  logic             frame_n_i,
    input  logic             irdy_n_i,
    input  logic             trdy_n_i,
    input  logic             par_i,
    input  logic             is_master_i,
    input  logic             is_write_i,
    input  logic             special_i,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             perr_n_o,
    output logic             perr_oe_o,
    output logic             perr_pulse_o
);
    phase_t ph;
    logic   par_calc;
    logic   err_report;

    pci_par_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n_i),
        .irdy_n    (irdy_n_i),
        .trdy_n    (trdy_n_i),
        .is_master (is_master_i),
        .is_write  (is_write_i),
        .special   (special_i),
        .ph        (ph)
    );

    pci_par_tree #(.AD_W(AD_W), .CBE_W(CBE_W)) u_tree (
        .ad  (ad_i),
        .cbe (cbe_n_i),
        .par (par_calc)
    );

    pci_par_gen u_gen (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .par_calc (par_calc),
        .par_o    (par_o),
        .par_oe_o (par_oe_o)
    );

    pci_par_chk u_chk (
        .clk          (clk),
        .rst          (rst),
        .ph           (ph),
        .par_calc     (par_calc),
        .par_i        (par_i),
        .err_pulse_o  (perr_pulse_o),
        .err_report_o (err_report)
    );

    pci_perr_drv #(.PERR_HOLD(PERR_HOLD)) u_perr (
        .clk        (clk),
        .rst        (rst),
        .err_report (err_report),
        .perr_n_o   (perr_n_o),
        .perr_oe_o  (perr_oe_o)
    );

    AST_PAR_EVEN: assert property (@(posedge clk) disable iff (rst)
        par_oe_o |-> (par_o == ^{$past(ad_i), $past(cbe_n_i)}))
        else $error("driven PAR not even"); // R1

    AST_PAR_OE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        par_oe_o |-> ($past(is_master_i && !frame_n_i)
                      || $past(is_master_i ? (is_write_i && !irdy_n_i)
                                           : (!is_write_i && !trdy_n_i))))
        else $error("PAR driven without cause"); // R5

    AST_PERR_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        (perr_oe_o && !perr_n_o) |-> perr_pulse_o)
        else $error("PERR# low without mismatch"); // R6

    AST_PERR_NOT_SPECIAL: assert property (@(posedge clk) disable iff (rst)
        (perr_oe_o && !perr_n_o) |-> !$past(special_i, 2))
        else $error("PERR# low for Special Cycle"); // R8

    AST_PULSE_NEEDS_XFER: assert property (@(posedge clk) disable iff (rst)
        perr_pulse_o |-> $past(!irdy_n_i && !trdy_n_i, 2))
        else $error("pulse without completed phase"); // R7

    AST_PULSE_RECEIVER: assert property (@(posedge clk) disable iff (rst)
        perr_pulse_o |-> $past(is_master_i != is_write_i, 2))
        else $error("pulse while sourcing"); // R12

endmodule

// File: tb/tb_pci_parity_unit.sv
module tb_pci_parity_unit;

    localparam int HOLD = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic        frame_n, irdy_n, trdy_n, par_in, master, write, special;
    logic        par_o, par_oe_o, perr_n_o, perr_oe_o, perr_pulse_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pci_parity_unit dut (
        .clk(clk), .rst(rst), .ad_i(ad), .cbe_n_i(cbe),
        .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
        .par_i(par_in), .is_master_i(master), .is_write_i(write),
        .special_i(special), .par_o(par_o), .par_oe_o(par_oe_o),
        .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o), .perr_pulse_o(perr_pulse_o)
    );

    // ---------------- expected-value model from the requirements ----------
    logic  m_fprev, m_xq, m_pq, m_sq, m_srcq;
    logic  e_par, e_paroe, e_pulse;
    int    m_st, m_cnt;          // 0 released, 1 low, 2 high
    string t_oe, t_perr, t_pulse;
    logic  prev_par;             // correct PAR for the last driven data

    function automatic logic par37(input logic [31:0] a, input logic [3:0] c);
        return ^{a, c};
    endfunction

    task automatic model_edge();
        logic addr, src, drv, err;
        if (rst) begin
            m_fprev = 1; m_xq = 0; m_pq = 0; m_sq = 0; m_srcq = 0;
            e_par = 0; e_paroe = 0; e_pulse = 0; m_st = 0; m_cnt = 0;
            t_oe = "R10"; t_perr = "R10"; t_pulse = "R10";
        end else begin
            addr = !frame_n && m_fprev;
            src  = master ? write : !write;
            drv  = (master && addr) || (src && (master ? !irdy_n : !trdy_n));
            err  = m_xq && (par_in != m_pq);
            e_pulse = err;
            t_pulse = m_xq ? "R6" : (m_srcq ? "R12" : "R7");
            if (err && !m_sq) begin
                t_perr = (m_st == 1) ? "R11" : "R6";
                m_st = 1;
            end else begin
                t_perr = err ? "R8" : "R9";
                if (m_st == 1) begin m_st = 2; m_cnt = HOLD - 1; end
                else if (m_st == 2) begin
                    if (m_cnt == 0) m_st = 0; else m_cnt--;
                end
            end
            e_paroe = drv;
            e_par   = par37(ad, cbe);
            t_oe    = (master && addr) ? "R2" : (drv ? (master ? "R3" : "R4") : "R5");
            m_xq    = !src && !irdy_n && !trdy_n;
            m_srcq  = src;
            m_pq    = par37(ad, cbe);
            m_sq    = special;
            m_fprev = frame_n;
        end
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(t_oe, "par_oe_o", par_oe_o, e_paroe);
        if (e_paroe) chk("R1", "par_o", par_o, e_par);
        chk(t_pulse, "perr_pulse_o", perr_pulse_o, e_pulse);
        chk(t_perr, "perr_oe_o", perr_oe_o, m_st != 0);
        chk(t_perr, "perr_n_o", perr_n_o, m_st != 1);
    endtask

    // one clock of stimulus; bad=1 flips PAR covering the previous clock
    task automatic cyc(input logic f, input logic i, input logic t, input logic m,
                       input logic w, input logic s, input logic bad);
        frame_n = f; irdy_n = i; trdy_n = t; master = m; write = w; special = s;
        par_in  = prev_par ^ bad;
        ad      = $urandom;
        cbe     = 4'($urandom);
        prev_par = par37(ad, cbe);
        tick();
    endtask

    task automatic idle(input int n, input logic bad_first);
        for (int k = 0; k < n; k++) cyc(1, 1, 1, 1, 0, 0, (k == 0) ? bad_first : 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_7a11));
        rst = 1; ad = 0; cbe = 0; frame_n = 1; irdy_n = 1; trdy_n = 1;
        par_in = 0; master = 1; write = 0; special = 0; prev_par = 0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R10", "reset par_oe_o", par_oe_o, 1'b0);
            chk("R10", "reset perr_oe_o", perr_oe_o, 1'b0);
            chk("R10", "reset perr_n_o", perr_n_o, 1'b1);
        end
        rst = 0;
        idle(1, 0);
        chk("R10", "post-reset perr_pulse_o", perr_pulse_o, 1'b0);

        // R2/R3: master write, address phase then burst
        cyc(0, 1, 1, 1, 1, 0, 0);
        cyc(0, 0, 1, 1, 1, 0, 0);
        cyc(1, 0, 0, 1, 1, 0, 0);
        idle(3, 0);

        // R4: target read burst
        cyc(0, 1, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        idle(3, 0);

        // R6/R9: master read, bad parity on single data phase
        cyc(0, 1, 1, 1, 0, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        idle(1, 1);
        chk("R6", "perr_pulse_o two clocks after data", perr_pulse_o, 1'b1);
        chk("R6", "perr_n_o two clocks after data", perr_n_o, 1'b0);
        idle(4, 0);

        // R8: same on a Special Cycle
        cyc(0, 1, 1, 1, 0, 1, 0);
        cyc(1, 0, 0, 1, 0, 1, 0);
        idle(1, 1);
        chk("R8", "special perr_oe_o", perr_oe_o, 1'b0);
        idle(3, 0);

        // R11: target write, back-to-back bad phases
        cyc(0, 1, 1, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 1);
        cyc(1, 0, 0, 0, 1, 0, 1);
        idle(5, 1);

        // error arriving during the high-drive window
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(1, 1, 1, 0, 1, 0, 1);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(1, 1, 1, 0, 1, 0, 1);
        idle(5, 0);

        // R7: IRDY# alone, bad PAR afterwards is ignored
        cyc(0, 0, 1, 0, 1, 0, 0);
        idle(1, 1);
        chk("R7", "no check without TRDY#", perr_pulse_o, 1'b0);
        idle(3, 0);

        // R12: master write completes with bad PAR, no check
        cyc(0, 0, 0, 1, 1, 0, 0);
        idle(1, 1);
        chk("R12", "sourcing agent no pulse", perr_pulse_o, 1'b0);
        idle(3, 0);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            cyc(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), ($urandom % 8) == 0, ($urandom % 6) == 0);
        end
        idle(6, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule